// File: doc/BRIEF.md
# Wired Interrupt Aggregation Controller

The block gathers a parameterised number of level-sensitive interrupt lines (forty by default, so more than one 32-bit word) and routes them to a small set of CPUs. Each line has a mask bit, a software trigger bit and a CPU target bitmap. Each CPU has one request output. The output is high while any unmasked, pending line targeted at that CPU is active.

Software uses a 32-bit register port. A request is one cycle of `regValid` with an address, write flag, write data and the index of the CPU making the access. Read data comes back on the next cycle with `rdValid`. Set and clear words change mask and trigger bits one word at a time: a 1 acts on its bit and a 0 leaves it alone. A CPU claims work by reading the event register. That read returns the lowest-numbered pending line aimed at the reading CPU and masks that line in the same cycle. Software unmasks it later through the mask-clear word.

Top module: `irqAggregator`

## Requirements
- R1: A read of byte address 0x0004 returns the implemented line count in bits 15:0, zero (die count minus one, a single die) in bits 27:24, and zero in all other bits.
- R2: A read of address 0x2000 returns the requesting CPU's index, taken from `regCpu`, zero-extended to 32 bits.
- R3: Mask bits sit in words at 0x4100 + 4*w (set) and 0x4180 + 4*w (clear), where line n uses word w = n/32, bit n mod 32. Writing a 1 to a bit sets or clears that mask bit, and writing a 0 has no effect. A read of either address returns the current mask word, with unimplemented bits reading 0. After reset every implemented line is masked.
- R4: Software trigger bits use the same word and bit indexing at 0x4000 + 4*w (set) and 0x4080 + 4*w (clear), with the same 1-acts/0-ignored write rule. A read of either address returns the current trigger word. Reset clears all trigger bits.
- R5: A line is pending when its input or its trigger bit is 1 and its mask bit is 0. A masked line never raises a request.
- R6: Line n has a target register at 0x3000 + 4*n whose low NUM_CPUS bits form a bitmap of the CPUs allowed to take it. The register can be read back, and it resets to 1 (CPU 0 only).
- R7: `irqOut[c]` is the OR of all pending lines whose target bitmap has bit c set, including lines that target several CPUs. It follows the state combinationally.
- R8: A read of 0x2004 by CPU c, when a line targeted at c is pending, returns die 0 in bits 31:24, type 1 (wired) in bits 23:16 and the lowest such line number in bits 15:0. The same clock edge sets that line's mask bit.
- R9: A read of 0x2004 with no pending line targeted at the reader returns 0 (type 0, no event) and changes no mask bit.
- R10: Every read gets exactly one `rdValid` pulse, in the cycle after the request. Writes produce none. Reads of unmapped or out-of-range addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regValid | input | 1 | Register access request this cycle |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | 16 | Byte address of the access |
| regWdata | input | 32 | Write data |
| regCpu | input | CPUW | Index of the CPU making the access |
| irqIn | input | NUM_LINES | Wired interrupt lines, active high |
| rdValid | output | 1 | Read data valid, one cycle after a read |
| rdData | output | 32 | Read data |
| irqOut | output | NUM_CPUS | Per-CPU interrupt request |

## Verification
The stimulus places pending lines on both sides of the 32-bit word boundary. A decoder that drops the word index would then mask or trigger the wrong line and misreport the upper word. Two lines pend for one CPU at once, which exposes a priority picker that returns the highest line, or one that fails to mask the claimed line and so returns the same line twice. An event read by a CPU that is not targeted must return type 0 without touching the masks. A multi-hot target must raise two outputs together, and a zero-data write to a mask word must leave the outputs unchanged, which catches a design that writes the word instead of acting bit by bit.

// File: rtl/irqAggPkg.sv
package irqAggPkg;
  localparam logic [15:0] ADDR_INFO   = 16'h0004;
  localparam logic [15:0] ADDR_WHOAMI = 16'h2000;
  localparam logic [15:0] ADDR_EVENT  = 16'h2004;
  localparam logic [3:0]  PAGE_TARGET = 4'h3;
  localparam logic [8:0]  PAGE_SWSET  = 9'h080;
  localparam logic [8:0]  PAGE_SWCLR  = 9'h081;
  localparam logic [8:0]  PAGE_MSKSET = 9'h082;
  localparam logic [8:0]  PAGE_MSKCLR = 9'h083;
  localparam logic [7:0]  EVT_NONE    = 8'd0;
  localparam logic [7:0]  EVT_WIRED   = 8'd1;

  typedef struct packed {
    logic        anyRd;
    logic        infoRd;
    logic        whoRd;
    logic        evtRd;
    logic        tgtRd;
    logic        tgtWr;
    logic        swRd;
    logic        swSetWr;
    logic        swClrWr;
    logic        mskRd;
    logic        mskSetWr;
    logic        mskClrWr;
    logic [15:0] idx;
  } regStrobe_t;
endpackage

// File: rtl/irqAggCtrl.sv
module irqAggCtrl
  import irqAggPkg::*;
#(
  parameter int NUM_LINES = 40
) (
  input  logic        regValid,
  input  logic        regWrite,
  input  logic [15:0] regAddr,
  output regStrobe_t  strb
);
  localparam int NW = (NUM_LINES + 31) / 32;

  logic       aligned;
  logic       wordOk;
  logic       tgtOk;
  logic [8:0] page;

  always_comb begin
    aligned = (regAddr[1:0] == 2'b00);
    page    = regAddr[15:7];
    wordOk  = aligned && (int'(regAddr[6:2]) < NW);
    tgtOk   = aligned && (regAddr[15:12] == PAGE_TARGET) &&
              (int'(regAddr[11:2]) < NUM_LINES);
    strb    = '0;
    if (regValid) begin
      strb.anyRd = !regWrite;
      if (tgtOk) begin
        strb.idx   = {6'b0, regAddr[11:2]};
        strb.tgtRd = !regWrite;
        strb.tgtWr = regWrite;
      end else if (wordOk) begin
        strb.idx = {11'b0, regAddr[6:2]};
        unique case (page)
          PAGE_SWSET: begin strb.swRd = !regWrite; strb.swSetWr = regWrite; end
          PAGE_SWCLR: begin strb.swRd = !regWrite; strb.swClrWr = regWrite; end
          PAGE_MSKSET: begin strb.mskRd = !regWrite; strb.mskSetWr = regWrite; end
          PAGE_MSKCLR: begin strb.mskRd = !regWrite; strb.mskClrWr = regWrite; end
          default: ;
        endcase
      end
      if (!regWrite) begin
        if (regAddr == ADDR_INFO)   strb.infoRd = 1'b1;
        if (regAddr == ADDR_WHOAMI) strb.whoRd  = 1'b1;
        if (regAddr == ADDR_EVENT)  strb.evtRd  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irqAggDatapath.sv
module irqAggDatapath
  import irqAggPkg::*;
#(
  parameter int NUM_LINES = 40,
  parameter int NUM_CPUS  = 4,
  parameter int CPUW      = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  regStrobe_t           strb,
  input  logic [31:0]          regWdata,
  input  logic [CPUW-1:0]      regCpu,
  input  logic [NUM_LINES-1:0] irqIn,
  output logic                 rdValid,
  output logic [31:0]          rdData,
  output logic [NUM_CPUS-1:0]  irqOut
);
  localparam int LINEW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  logic [NUM_LINES-1:0] maskQ, maskD;
  logic [NUM_LINES-1:0] swQ, swD;
  logic [NUM_CPUS-1:0]  tgtQ [NUM_LINES];
  logic [NUM_LINES-1:0] pending;
  logic [NUM_LINES-1:0] cand;
  logic                 pickHit;
  logic [LINEW-1:0]     pickIdx;
  logic [31:0]          rdD;

  function automatic logic [31:0] wordOf(input logic [NUM_LINES-1:0] v,
                                         input logic [15:0] w);
    logic [31:0] r;
    r = '0;
    for (int b = 0; b < 32; b++) begin
      if (int'(w) * 32 + b < NUM_LINES) r[b] = v[int'(w) * 32 + b];
    end
    return r;
  endfunction

  assign pending = (irqIn | swQ) & ~maskQ;

  genvar c, n;
  generate
    for (c = 0; c < NUM_CPUS; c++) begin : g_cpu
      logic [NUM_LINES-1:0] hitsForCpu;
      for (n = 0; n < NUM_LINES; n++) begin : g_line
        assign hitsForCpu[n] = pending[n] & tgtQ[n][c];
      end
      assign irqOut[c] = |hitsForCpu;
    end
    for (n = 0; n < NUM_LINES; n++) begin : g_cand
      assign cand[n] = pending[n] & tgtQ[n][regCpu];
    end
  endgenerate

  always_comb begin
    pickHit = 1'b0;
    pickIdx = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (cand[i]) begin
        pickHit = 1'b1;
        pickIdx = LINEW'(i);
      end
    end
  end

  always_comb begin
    maskD = maskQ;
    swD   = swQ;
    for (int i = 0; i < NUM_LINES; i++) begin
      if ((i / 32) == int'(strb.idx) && regWdata[i % 32]) begin
        if (strb.mskSetWr) maskD[i] = 1'b1;
        if (strb.mskClrWr) maskD[i] = 1'b0;
        if (strb.swSetWr)  swD[i]   = 1'b1;
        if (strb.swClrWr)  swD[i]   = 1'b0;
      end
      if (strb.evtRd && pickHit && (int'(pickIdx) == i)) maskD[i] = 1'b1;
    end
  end

  always_comb begin
    rdD = '0;
    if (strb.infoRd) rdD = {4'b0, 4'd0, 8'b0, 16'(NUM_LINES)};
    if (strb.whoRd)  rdD = 32'(regCpu);
    if (strb.evtRd)  rdD = pickHit ? {8'd0, EVT_WIRED, 16'(pickIdx)}
                                   : {8'd0, EVT_NONE, 16'd0};
    if (strb.tgtRd)  rdD = 32'(tgtQ[strb.idx[LINEW-1:0]]);
    if (strb.swRd)   rdD = wordOf(swQ, strb.idx);
    if (strb.mskRd)  rdD = wordOf(maskQ, strb.idx);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ   <= '1;
      swQ     <= '0;
      rdValid <= 1'b0;
      rdData  <= '0;
      for (int i = 0; i < NUM_LINES; i++) tgtQ[i] <= NUM_CPUS'(1);
    end else begin
      maskQ   <= maskD;
      swQ     <= swD;
      rdValid <= strb.anyRd;
      rdData  <= rdD;
      for (int i = 0; i < NUM_LINES; i++) begin
        if (strb.tgtWr && int'(strb.idx) == i) tgtQ[i] <= regWdata[NUM_CPUS-1:0];
      end
    end
  end

  // R8: the claimed line is masked one edge later
  p_evt_masks_line_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.evtRd && pickHit) |=> (maskQ[$past(pickIdx)] && rdData[23:16] == EVT_WIRED));

  // R9: empty event read returns zero and leaves masks alone
  p_evt_empty_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.evtRd && !pickHit) |=> (rdData == 32'd0 && $stable(maskQ)));

  // R3: zero data to a mask word changes nothing
  p_zero_write_noop_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.mskSetWr || strb.mskClrWr) && regWdata == 32'd0) |=> $stable(maskQ));

  // R5: with every line masked no CPU is requested
  p_all_masked_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    (&maskQ) |-> (irqOut == '0));

  // R10: a read is answered on the next edge
  p_read_answered_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.anyRd) |=> rdValid);
endmodule

// File: rtl/irqAggregator.sv
module irqAggregator
  import irqAggPkg::*;
#(
  parameter int NUM_LINES = 40,
  parameter int NUM_CPUS  = 4,
  parameter int CPUW      = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regValid,
  input  logic                 regWrite,
  input  logic [15:0]          regAddr,
  input  logic [31:0]          regWdata,
  input  logic [CPUW-1:0]      regCpu,
  input  logic [NUM_LINES-1:0] irqIn,
  output logic                 rdValid,
  output logic [31:0]          rdData,
  output logic [NUM_CPUS-1:0]  irqOut
);
  regStrobe_t strb;

  irqAggCtrl #(.NUM_LINES(NUM_LINES)) u_ctrl (
    .regValid(regValid),
    .regWrite(regWrite),
    .regAddr (regAddr),
    .strb    (strb)
  );

  irqAggDatapath #(.NUM_LINES(NUM_LINES), .NUM_CPUS(NUM_CPUS), .CPUW(CPUW)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .regWdata(regWdata),
    .regCpu  (regCpu),
    .irqIn   (irqIn),
    .rdValid (rdValid),
    .rdData  (rdData),
    .irqOut  (irqOut)
  );
endmodule

// File: tb/irqAggregator_bench.sv
`timescale 1ns/1ps
module irqAggregator_bench;
  localparam int NL = 40;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regValid = 1'b0;
  logic          regWrite = 1'b0;
  logic [15:0]   regAddr = '0;
  logic [31:0]   regWdata = '0;
  logic [1:0]    regCpu = '0;
  logic [NL-1:0] irqIn = '0;
  logic          rdValid;
  logic [31:0]   rdData;
  logic [NC-1:0] irqOut;

  int checks = 0;
  int errors = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #2.5 clk = ~clk;

  irqAggregator #(.NUM_LINES(NL), .NUM_CPUS(NC)) u_irqAggregator (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .regCpu(regCpu), .irqIn(irqIn),
    .rdValid(rdValid), .rdData(rdData), .irqOut(irqOut)
  );

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R10 unexpected rdValid: actual %h expected none", rdData);
      end else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (rdData !== e) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", t, rdData, e);
        end
      end
    end
  end

  task automatic rdReq(input logic [15:0] a, input logic [1:0] cpu,
                       input logic [31:0] exp, input string tag);
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b0; regAddr = a; regCpu = cpu;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk);
    regValid = 1'b0;
  endtask

  task automatic wrReq(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b1; regAddr = a; regWdata = d; regCpu = 2'd0;
    @(negedge clk);
    regValid = 1'b0; regWrite = 1'b0;
  endtask

  task automatic checkIrq(input logic [NC-1:0] exp, input string tag);
    @(negedge clk);
    checks++;
    if (irqOut !== exp) begin
      errors++;
      $display("FAIL %s: irqOut actual %b expected %b", tag, irqOut, exp);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    checkIrq(4'b0000, "R7 reset quiet");
    rdReq(16'h0004, 2'd0, 32'h0000_0028, "R1 info");
    rdReq(16'h4100, 2'd0, 32'hFFFF_FFFF, "R3 reset mask word0");
    rdReq(16'h4104, 2'd0, 32'h0000_00FF, "R3 reset mask word1");
    rdReq(16'h2000, 2'd2, 32'd2, "R2 whoami cpu2");
    rdReq(16'h2000, 2'd3, 32'd3, "R2 whoami cpu3");
    rdReq(16'h3014, 2'd0, 32'd1, "R6 target reset");
    rdReq(16'h2004, 2'd0, 32'd0, "R9 empty event");
    // masked input raises nothing
    irqIn[3] = 1'b1;
    checkIrq(4'b0000, "R5 masked input");
    wrReq(16'h4180, 32'h0000_0008);
    checkIrq(4'b0001, "R7 line3 to cpu0");
    wrReq(16'h4100, 32'h0000_0000);
    checkIrq(4'b0001, "R3 zero write no effect");
    irqIn[10] = 1'b1;
    wrReq(16'h4180, 32'h0000_0400);
    rdReq(16'h2004, 2'd0, 32'h0001_0003, "R8 lowest first");
    rdReq(16'h4100, 2'd0, 32'hFFFF_FBFF, "R8 claimed line masked");
    rdReq(16'h2004, 2'd0, 32'h0001_000A, "R8 second line");
    checkIrq(4'b0000, "R8 all claimed");
    rdReq(16'h2004, 2'd0, 32'd0, "R9 nothing left");
    // upper word, software trigger
    wrReq(16'h308C, 32'h0000_0004);
    rdReq(16'h308C, 2'd0, 32'd4, "R6 target readback");
    wrReq(16'h4004, 32'h0000_0008);
    rdReq(16'h4004, 2'd0, 32'h0000_0008, "R4 sw set word1");
    wrReq(16'h4184, 32'h0000_0008);
    checkIrq(4'b0100, "R7 line35 to cpu2");
    rdReq(16'h2004, 2'd0, 32'd0, "R9 untargeted reader");
    rdReq(16'h4184, 2'd0, 32'h0000_00F7, "R9 masks untouched");
    rdReq(16'h2004, 2'd2, 32'h0001_0023, "R8 line35 cpu2");
    checkIrq(4'b0000, "R8 line35 claimed");
    wrReq(16'h4084, 32'h0000_0008);
    rdReq(16'h4084, 2'd0, 32'h0000_0000, "R4 sw clear");
    wrReq(16'h4184, 32'h0000_0008);
    checkIrq(4'b0000, "R5 no source");
    // multi-hot target
    wrReq(16'h300C, 32'h0000_000A);
    wrReq(16'h4180, 32'h0000_0008);
    checkIrq(4'b1010, "R7 multi-hot");
    rdReq(16'h2004, 2'd1, 32'h0001_0003, "R8 cpu1 claims");
    checkIrq(4'b0000, "R8 multi-hot claimed");
    rdReq(16'h1000, 2'd0, 32'd0, "R10 unmapped");
    rdReq(16'h4108, 2'd0, 32'd0, "R10 out of range word");
    repeat (4) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R10 missing responses: actual %0d expected 0", expQ.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule